// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time in packed BCD and makes it visible to a host through a byte-wide register window. The host drives an address, a write strobe and a data byte. Writes land on the next clock edge, and reads return the addressed byte combinationally. Every write to a time or alarm field is masked to that field's width and checked against the field's legal BCD range. A value that fails the check, including one with a decimal digit above 9, is dropped and the register keeps its old contents.

A one-cycle tick input, normally pulsed once per second, advances the clock. The carries run from seconds through minutes and hours into the day of week, the day of month, the month and the year. The month length and leap years are handled. A parameter picks how the two-digit year maps onto centuries, and that choice decides whether year 00 is a leap year. After every advance the running time is compared with four alarm registers. On a match the interrupt output pulses high for a single cycle.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the time reads 00:00:00 with day of week 01, date 01, month 01 and year 00. All alarm registers read 00, and irq_o is low.
- R2: The seven time registers sit at the seven highest addresses of the window, 0x1FF9 up to 0x1FFF, in the order seconds, minutes, hours, day of week, date, month, year. When ALIAS_LOW is set, the same registers also answer reads and writes at 0x07F9 up to 0x07FF.
- R3: A seconds or minutes write keeps data bits 6:0 and is accepted only if both BCD digits are 0-9 and the value is 00 to 59. A rejected write, including one with a digit above 9, leaves the register unchanged.
- R4: An hours write keeps bits 5:0 and is accepted only for legal BCD 00 to 23. A day-of-week write keeps bits 2:0 and is always accepted.
- R5: A date write keeps bits 5:0 and needs legal BCD 01 to 31. A month write keeps bits 4:0 and needs legal BCD 01 to 12. A year write uses all 8 bits and needs legal BCD 00 to 99.
- R6: A seconds read returns in bit 7 the bit 7 of the last accepted seconds write, and in bits 6:0 the seconds count. Ticks never alter bit 7.
- R7: A tick advances the seconds. Each rollover carries into the next field: 59 to 00 for seconds and minutes, 23 to 00 for hours, month 12 to 01, and year 99 to 00. A day rollover steps the day of week, which wraps from 7 to 1.
- R8: The date rolls to 01 after day 31, 30 or 28/29, depending on the month. A year is a leap year when it is divisible by 4, except that year 00 is not a leap year when YEAR_FROM_1968 is 0.
- R9: The alarm seconds, minutes, hours and date registers are at 0x1FF2 up to 0x1FF5. They use the same masks and range checks as the matching time fields. An accepted write stores and reads back the whole byte.
- R10: When a tick leaves the time equal to the alarm seconds, minutes and hours, irq_o is high for exactly one cycle, one cycle after the new time becomes readable. The date must also match unless bit 7 of the alarm date register is 1.
- R11: Any other address reads as 0xFF, and writes to it change no register.
- R12: A tick that arrives in the same cycle as an accepted time write is applied one cycle later. A tick that coincides with a rejected write is applied at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (13) | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| tick_i | input | 1 | One-cycle time advance pulse |
| irq_o | output | 1 | One-cycle alarm pulse |

## Verification
A wrong time register appears on the very next read of that address. A broken carry stays hidden until a tick crosses the faulty boundary, so the bench loads 23:59:59 on the last day of a month or year and ticks once. A bad month-length or leap-year rule shows only on the day after the last day of February, April or December. A wrong alarm comparison shows as a missing or extra irq_o pulse exactly two edges after the tick. A pending-tick fault shows as a seconds value off by one, one cycle after a write that collides with a tick.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int BYTE_W = 8;

  // Order matters: time fields follow address order, alarm fields likewise.
  typedef enum logic [3:0] {
    F_NONE, F_SEC, F_MIN, F_HOUR, F_WDAY, F_MDAY, F_MON, F_YEAR,
    F_ASEC, F_AMIN, F_AHOUR, F_AMDAY
  } field_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] mins;
    logic [5:0] hrs;
    logic [2:0] wday;
    logic [5:0] mday;
    logic [4:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  function automatic logic digits_ok(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_time_field(input field_e f);
    return (f >= F_SEC) && (f <= F_YEAR);
  endfunction

  function automatic logic is_alarm_field(input field_e f);
    return (f >= F_ASEC) && (f <= F_AMDAY);
  endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int LOW_ADDR_W = 11,
  parameter bit ALIAS_LOW  = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output field_e            field_o
);
  localparam int N_TIME  = 7;
  localparam int N_ALARM = 4;
  localparam logic [ADDR_W-1:0] TIME_HI  = ADDR_W'((1 << ADDR_W) - N_TIME);
  localparam logic [ADDR_W-1:0] TIME_LO  = ADDR_W'((1 << LOW_ADDR_W) - N_TIME);
  localparam logic [ADDR_W-1:0] ALARM_BS = ADDR_W'((1 << ADDR_W) - 2 * N_TIME);

  logic lo_en;

  generate
    if (ALIAS_LOW) begin : g_alias
      assign lo_en = 1'b1;
    end else begin : g_no_alias
      assign lo_en = 1'b0;
    end
  endgenerate

  always_comb begin
    field_o = F_NONE;
    for (int k = 0; k < N_TIME; k++) begin
      if (addr_i == TIME_HI + ADDR_W'(k))
        field_o = field_e'(int'(F_SEC) + k);
      if (lo_en && addr_i == TIME_LO + ADDR_W'(k))
        field_o = field_e'(int'(F_SEC) + k);
    end
    for (int k = 0; k < N_ALARM; k++) begin
      if (addr_i == ALARM_BS + ADDR_W'(k))
        field_o = field_e'(int'(F_ASEC) + k);
    end
  end

endmodule

// File: rtl/rtc_write_check.sv
module rtc_write_check
  import bcd_rtc_pkg::*;
(
  input  field_e            field_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              ok_o
);
  logic [7:0] m;

  always_comb begin
    m    = 8'h00;
    ok_o = 1'b0;
    unique case (field_i)
      F_SEC, F_MIN, F_ASEC, F_AMIN: begin
        m    = {1'b0, wdata_i[6:0]};
        ok_o = digits_ok(m) && (m <= 8'h59);
      end
      F_HOUR, F_AHOUR: begin
        m    = {2'b0, wdata_i[5:0]};
        ok_o = digits_ok(m) && (m <= 8'h23);
      end
      F_WDAY: ok_o = 1'b1;
      F_MDAY, F_AMDAY: begin
        m    = {2'b0, wdata_i[5:0]};
        ok_o = digits_ok(m) && (m != 8'h00) && (m <= 8'h31);
      end
      F_MON: begin
        m    = {3'b0, wdata_i[4:0]};
        ok_o = digits_ok(m) && (m != 8'h00) && (m <= 8'h12);
      end
      F_YEAR: ok_o = digits_ok(wdata_i);
      default: ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import bcd_rtc_pkg::*;
#(
  parameter bit YEAR_FROM_1968 = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  field_e            field_i,
  input  logic              we_i,
  input  logic              ok_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              tick_i,
  output rtc_time_t         time_o,
  output logic              flag_o,
  output logic              adv_o,
  output logic              pend_o
);
  rtc_time_t t_q, t_n;
  logic flag_q, pend_q, adv_q;
  logic wr_time, due;
  logic sec_end, min_end, hr_end, day_end, mon_end;
  logic div4, leap;
  logic [5:0] last_day;

  assign wr_time = we_i && ok_i && is_time_field(field_i);
  assign due     = tick_i || pend_q;

  // 10t+o is a multiple of 4 iff (2t+o) is
  assign div4 = t_q.yr[4] ? (t_q.yr[1:0] == 2'b10) : (t_q.yr[1:0] == 2'b00);

  generate
    if (YEAR_FROM_1968) begin : g_base68
      assign leap = div4;
    end else begin : g_base00
      assign leap = div4 && (t_q.yr != 8'h00);
    end
  endgenerate

  always_comb begin
    unique case (t_q.mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

  assign sec_end = (t_q.sec == 7'h59);
  assign min_end = sec_end && (t_q.mins == 7'h59);
  assign hr_end  = min_end;
  assign day_end = hr_end && (t_q.hrs == 6'h23);
  assign mon_end = day_end && (t_q.mday >= last_day);

  always_comb begin
    t_n     = t_q;
    t_n.sec = sec_end ? 7'h00 : 7'(bcd_inc(8'(t_q.sec)));
    if (sec_end)
      t_n.mins = (t_q.mins == 7'h59) ? 7'h00 : 7'(bcd_inc(8'(t_q.mins)));
    if (hr_end)
      t_n.hrs = (t_q.hrs == 6'h23) ? 6'h00 : 6'(bcd_inc(8'(t_q.hrs)));
    if (day_end) begin
      t_n.wday = (t_q.wday == 3'd7 || t_q.wday == 3'd0) ? 3'd1 : t_q.wday + 3'd1;
      t_n.mday = mon_end ? 6'h01 : 6'(bcd_inc(8'(t_q.mday)));
    end
    if (mon_end) begin
      t_n.mon = (t_q.mon == 5'h12) ? 5'h01 : 5'(bcd_inc(8'(t_q.mon)));
      if (t_q.mon == 5'h12)
        t_n.yr = (t_q.yr == 8'h99) ? 8'h00 : bcd_inc(t_q.yr);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q    <= '{sec: 7'h00, mins: 7'h00, hrs: 6'h00, wday: 3'd1,
                  mday: 6'h01, mon: 5'h01, yr: 8'h00};
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      adv_q <= 1'b0;
      if (wr_time) begin
        pend_q <= due;
        unique case (field_i)
          F_SEC: begin
            t_q.sec <= wdata_i[6:0];
            flag_q  <= wdata_i[7];
          end
          F_MIN:  t_q.mins <= wdata_i[6:0];
          F_HOUR: t_q.hrs  <= wdata_i[5:0];
          F_WDAY: t_q.wday <= wdata_i[2:0];
          F_MDAY: t_q.mday <= wdata_i[5:0];
          F_MON:  t_q.mon  <= wdata_i[4:0];
          default: t_q.yr  <= wdata_i;
        endcase
      end else if (due) begin
        t_q    <= t_n;
        pend_q <= 1'b0;
        adv_q  <= 1'b1;
      end
    end
  end

  assign time_o = t_q;
  assign flag_o = flag_q;
  assign adv_o  = adv_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import bcd_rtc_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  field_e                  field_i,
  input  logic                    we_i,
  input  logic                    ok_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  input  rtc_time_t               time_i,
  input  logic                    adv_i,
  output logic [3:0][BYTE_W-1:0]  al_o,
  output logic                    irq_o
);
  localparam int N_AL = 4;

  logic [N_AL-1:0][BYTE_W-1:0] al_q;
  logic hit, irq_q;

  generate
    for (genvar g = 0; g < N_AL; g++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          al_q[g] <= '0;
        else if (we_i && ok_i && field_i == field_e'(int'(F_ASEC) + g))
          al_q[g] <= wdata_i;
      end
    end
  endgenerate

  // al_q[3][7] set: date excluded from the compare
  assign hit = (time_i.sec  == al_q[0][6:0]) &&
               (time_i.mins == al_q[1][6:0]) &&
               (time_i.hrs  == al_q[2][5:0]) &&
               (al_q[3][7] || time_i.mday == al_q[3][5:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= adv_i && hit;
  end

  assign al_o  = al_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int LOW_ADDR_W     = 11,
  parameter bit ALIAS_LOW      = 1'b1,
  parameter bit YEAR_FROM_1968 = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  output logic              irq_o
);
  field_e    field_w;
  logic      ok_w, flag_w, adv_w, pend_w;
  rtc_time_t time_w;
  logic [3:0][BYTE_W-1:0] al_w;

  rtc_addr_decode #(
    .ADDR_W(ADDR_W), .LOW_ADDR_W(LOW_ADDR_W), .ALIAS_LOW(ALIAS_LOW)
  ) u_dec (
    .addr_i (addr_i),
    .field_o(field_w)
  );

  rtc_write_check u_chk (
    .field_i(field_w),
    .wdata_i(wdata_i),
    .ok_o   (ok_w)
  );

  rtc_time_counter #(.YEAR_FROM_1968(YEAR_FROM_1968)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .field_i(field_w),
    .we_i   (we_i),
    .ok_i   (ok_w),
    .wdata_i(wdata_i),
    .tick_i (tick_i),
    .time_o (time_w),
    .flag_o (flag_w),
    .adv_o  (adv_w),
    .pend_o (pend_w)
  );

  rtc_alarm u_alm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .field_i(field_w),
    .we_i   (we_i),
    .ok_i   (ok_w),
    .wdata_i(wdata_i),
    .time_i (time_w),
    .adv_i  (adv_w),
    .al_o   (al_w),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (field_w)
      F_SEC:   rdata_o = {flag_w, time_w.sec};
      F_MIN:   rdata_o = {1'b0, time_w.mins};
      F_HOUR:  rdata_o = {2'b0, time_w.hrs};
      F_WDAY:  rdata_o = {5'b0, time_w.wday};
      F_MDAY:  rdata_o = {2'b0, time_w.mday};
      F_MON:   rdata_o = {3'b0, time_w.mon};
      F_YEAR:  rdata_o = time_w.yr;
      F_ASEC:  rdata_o = al_w[0];
      F_AMIN:  rdata_o = al_w[1];
      F_AHOUR: rdata_o = al_w[2];
      F_AMDAY: rdata_o = al_w[3];
      default: rdata_o = 8'hFF;
    endcase
  end

endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk
  import bcd_rtc_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      irq_i,
  input logic      adv_i,
  input logic      pend_i,
  input logic      we_i,
  input logic      tick_i,
  input rtc_time_t time_i,
  input logic      flag_i
);

  // R10
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  // R10
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(adv_i));

  // R3
  sec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i.sec <= 7'h59 && time_i.sec[3:0] <= 4'd9 &&
    time_i.mins <= 7'h59 && time_i.mins[3:0] <= 4'd9);

  // R4
  hour_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i.hrs <= 6'h23 && time_i.hrs[3:0] <= 4'd9);

  // R5
  date_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_i.mday != 6'h00 && time_i.mday <= 6'h31 &&
    time_i.mon != 5'h00 && time_i.mon <= 5'h12);

  // R12
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !tick_i && !pend_i) |=> $stable(time_i));

  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flag_i));

endmodule

bind bcd_rtc_regs rtc_regs_chk chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .irq_i (irq_o),
  .adv_i (adv_w),
  .pend_i(pend_w),
  .we_i  (we_i),
  .tick_i(tick_i),
  .time_i(time_w),
  .flag_i(flag_w)
);

// File: tb/bcd_rtc_regs_tb_top.sv
module bcd_rtc_regs_tb_top;

  localparam logic [12:0] A_SEC  = 13'h1FF9;
  localparam logic [12:0] A_MIN  = 13'h1FFA;
  localparam logic [12:0] A_HOUR = 13'h1FFB;
  localparam logic [12:0] A_WDAY = 13'h1FFC;
  localparam logic [12:0] A_MDAY = 13'h1FFD;
  localparam logic [12:0] A_MON  = 13'h1FFE;
  localparam logic [12:0] A_YEAR = 13'h1FFF;
  localparam logic [12:0] L_ASEC = 13'h1FF2;
  localparam logic [12:0] L_AMIN = 13'h1FF3;
  localparam logic [12:0] L_AHR  = 13'h1FF4;
  localparam logic [12:0] L_ADAY = 13'h1FF5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic tick = 1'b0;
  logic [7:0] rd_a, rd_b;
  logic irq_a, irq_b;
  logic mon_req = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_irq;
    bit         sel_b;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  bcd_rtc_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rd_a), .tick_i(tick), .irq_o(irq_a)
  );

  bcd_rtc_regs #(.YEAR_FROM_1968(1'b1)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rd_b), .tick_i(tick), .irq_o(irq_b)
  );

  // monitor
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    if (mon_req && sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = it.is_irq ? {7'b0, irq_a} : (it.sel_b ? rd_b : rd_a);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [7:0] e, input string tag,
                    input bit b = 1'b0);
    item_t it;
    addr = a;
    it = '{is_irq: 1'b0, sel_b: b, exp: e, tag: tag};
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it = '{is_irq: 1'b1, sel_b: 1'b0, exp: {7'b0, e}, tag: tag};
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic tick1();
    @(posedge clk); #1 tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
  endtask

  task automatic end_of_day(input logic [7:0] yr, input logic [7:0] mo,
                            input logic [7:0] dy);
    wr(A_YEAR, yr); wr(A_MON, mo); wr(A_MDAY, dy);
    wr(A_HOUR, 8'h23); wr(A_MIN, 8'h59); wr(A_SEC, 8'h59);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_SEC, 8'h00, "R1"); rd(A_MIN, 8'h00, "R1"); rd(A_HOUR, 8'h00, "R1");
    rd(A_WDAY, 8'h01, "R1"); rd(A_MDAY, 8'h01, "R1"); rd(A_MON, 8'h01, "R1");
    rd(A_YEAR, 8'h00, "R1"); rd(L_ASEC, 8'h00, "R1"); rd(L_ADAY, 8'h00, "R1");
    chk_irq(1'b0, "R1");

    // R6 flag, R3 seconds/minutes checks
    wr(A_SEC, 8'hC5); rd(A_SEC, 8'hC5, "R6");
    wr(A_SEC, 8'h60); rd(A_SEC, 8'hC5, "R3");
    wr(A_SEC, 8'h3A); rd(A_SEC, 8'hC5, "R3");
    wr(A_SEC, 8'h59); rd(A_SEC, 8'h59, "R6");
    wr(A_MIN, 8'hDA); rd(A_MIN, 8'h00, "R3");
    wr(A_MIN, 8'hB0); rd(A_MIN, 8'h30, "R3");

    // R4
    wr(A_HOUR, 8'h24); rd(A_HOUR, 8'h00, "R4");
    wr(A_HOUR, 8'hE3); rd(A_HOUR, 8'h23, "R4");
    wr(A_WDAY, 8'hFE); rd(A_WDAY, 8'h06, "R4");

    // R5
    wr(A_MDAY, 8'h00); rd(A_MDAY, 8'h01, "R5");
    wr(A_MDAY, 8'h32); rd(A_MDAY, 8'h01, "R5");
    wr(A_MDAY, 8'h31); rd(A_MDAY, 8'h31, "R5");
    wr(A_MON, 8'h13);  rd(A_MON, 8'h01, "R5");
    wr(A_MON, 8'h12);  rd(A_MON, 8'h12, "R5");
    wr(A_YEAR, 8'h9A); rd(A_YEAR, 8'h00, "R5");
    wr(A_YEAR, 8'h99); rd(A_YEAR, 8'h99, "R5");

    // R7 full carry chain
    wr(A_MIN, 8'h59); wr(A_WDAY, 8'h07);
    tick1();
    rd(A_SEC, 8'h00, "R7"); rd(A_MIN, 8'h00, "R7"); rd(A_HOUR, 8'h00, "R7");
    rd(A_WDAY, 8'h01, "R7"); rd(A_MDAY, 8'h01, "R7"); rd(A_MON, 8'h01, "R7");
    rd(A_YEAR, 8'h00, "R7"); rd(A_YEAR, 8'h00, "R7", 1'b1);

    // R2 alias window
    wr(13'h07FA, 8'h17);
    rd(A_MIN, 8'h17, "R2"); rd(13'h07FA, 8'h17, "R2"); rd(13'h07F9, 8'h00, "R2");

    // R11 unmapped
    rd(13'h1FF0, 8'hFF, "R11");
    wr(13'h1FF8, 8'h12); rd(13'h1FF8, 8'hFF, "R11");
    rd(13'h0100, 8'hFF, "R11");
    wr(13'h0FFA, 8'h05); rd(A_MIN, 8'h17, "R11");

    // R8 month length and leap years
    end_of_day(8'h00, 8'h02, 8'h28);
    tick1();
    rd(A_MON, 8'h03, "R8"); rd(A_MDAY, 8'h01, "R8");
    rd(A_MON, 8'h02, "R8", 1'b1); rd(A_MDAY, 8'h29, "R8", 1'b1);
    end_of_day(8'h04, 8'h02, 8'h28);
    tick1();
    rd(A_MON, 8'h02, "R8"); rd(A_MDAY, 8'h29, "R8");
    wr(A_HOUR, 8'h23); wr(A_MIN, 8'h59); wr(A_SEC, 8'h59);
    tick1();
    rd(A_MON, 8'h03, "R8"); rd(A_MDAY, 8'h01, "R8");
    end_of_day(8'h04, 8'h04, 8'h30);
    tick1();
    rd(A_MON, 8'h05, "R8"); rd(A_MDAY, 8'h01, "R8");

    // R9 alarm registers
    wr(L_ASEC, 8'h8A); rd(L_ASEC, 8'h00, "R9");
    wr(L_ASEC, 8'h10); rd(L_ASEC, 8'h10, "R9");
    wr(L_AHR, 8'h24);  rd(L_AHR, 8'h00, "R9");
    wr(L_AMIN, 8'h00); wr(L_AHR, 8'h00);
    wr(L_ADAY, 8'h00); rd(L_ADAY, 8'h00, "R9");
    wr(L_ADAY, 8'hC1); rd(L_ADAY, 8'hC1, "R9");

    // R10 alarm match, date excluded
    wr(A_SEC, 8'h09);
    tick1();
    chk_irq(1'b1, "R10"); chk_irq(1'b0, "R10");
    // date included and mismatching
    wr(L_ADAY, 8'h15);
    wr(A_SEC, 8'h09);
    tick1();
    chk_irq(1'b0, "R10"); chk_irq(1'b0, "R10");
    // date included and matching
    wr(A_MDAY, 8'h15); wr(A_SEC, 8'h09);
    tick1();
    chk_irq(1'b1, "R10"); chk_irq(1'b0, "R10");

    // R12 tick colliding with accepted write is deferred
    @(posedge clk); #1;
    addr = A_MIN; wdata = 8'h20; we = 1'b1; tick = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; tick = 1'b0;
    rd(A_SEC, 8'h10, "R12");
    @(posedge clk); #1;
    rd(A_SEC, 8'h11, "R12"); rd(A_MIN, 8'h20, "R12");
    // tick colliding with rejected write applies at once
    @(posedge clk); #1;
    addr = A_SEC; wdata = 8'h77; we = 1'b1; tick = 1'b1;
    @(posedge clk); #1;
    we = 1'b0; tick = 1'b0;
    rd(A_SEC, 8'h12, "R12");

    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule